// File: doc/BRIEF.md
# Sleep Mode Entry/Exit Controller

This controller sequences a synchronous memory into and out of a low-power sleep state. The sleep request arrives from outside the clock domain, so it passes through a synchroniser. The controller commits to sleep a fixed number of clocks after the synchronised request rises, and it wakes the same fixed number of clocks after the request falls. While asleep it raises a flag that the surrounding datapath uses to block every array access. On the first sleep cycle it pulses an invalidate line, so that any operation still in flight is dropped rather than completed.

After wake-up, the controller holds a recovery window of a parameterised length. During that window the chip enables must stay idle. Any enable seen in the window sets a sticky error. Asking for sleep while an access is still busy sets the same error. Only reset clears it. The reset is asserted asynchronously and released synchronously inside the block.

Top module: `sleep_ctl`

## Requirements
- R1: After reset, sleep_o, flush_o, recov_o and err_o are all 0.
- R2: sleep_o rises ENTRY_CYC (default 2) clocks after the synchronised request rises. The synchroniser has 2 stages. A request driven between edges is therefore seen with sleep_o high after the 4th rising edge, and still low after the 3rd.
- R3: sleep_o falls EXIT_CYC (default 2) clocks after the synchronised request falls.
- R4: flush_o is high for exactly one cycle, the first cycle in which sleep_o is high.
- R5: A request that is withdrawn before entry completes produces no sleep and no flush. With defaults, this applies to a request high across only one rising edge.
- R6: If the request returns while the exit is in progress, the block stays asleep. It opens no recovery window and issues no new flush.
- R7: recov_o is high for RECOV_CYC (default 2) cycles, starting in the cycle in which sleep_o falls. It is never high together with sleep_o.
- R8: Any sel_i bit that is high in a cycle where recov_o is high sets err_o one clock later.
- R9: If busy_i is high when the block first acts on a synchronised request, err_o is set. Entry into sleep still proceeds.
- R10: err_o is sticky until reset. sel_i activity outside the recovery window does not set it, and neither does busy_i without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside the block |
| sleep_req_a | input | 1 | Sleep request, asynchronous to clk |
| sel_i | input | N_SEL | Chip enables, active high |
| busy_i | input | 1 | An access is in progress |
| sleep_o | output | 1 | Sleep active; blocks array access |
| flush_o | output | 1 | One-cycle invalidate for pending operations |
| recov_o | output | 1 | Recovery window active |
| err_o | output | 1 | Sticky protocol violation flag |

## Verification
The hardest case to reach from the ports is a request that changes while a transition is under way. This covers a request dropped between synchronisation and commitment, and a request reasserted during the exit countdown. The bench reaches these cases by sweeping the width of the request pulse in whole clocks and by reopening the request one clock after release. The expected sleep, flush and recovery cycles come from pipeline arithmetic. The recovery rule is exercised by placing a single-cycle enable at every offset around the window, on every enable bit.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;
  typedef enum logic [2:0] {
    ST_AWAKE = 3'd0,
    ST_ENTER = 3'd1,
    ST_SLEEP = 3'd2,
    ST_EXIT  = 3'd3,
    ST_RECOV = 3'd4
  } slp_state_t;
endpackage

// File: rtl/sleep_rst_sync.sv
module sleep_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] rs_q;
  logic [STAGES-1:0] rs_d;

  always_comb rs_d = {rs_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end

  assign rst_ns = rs_q[STAGES-1];
endmodule

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_a,
  output logic q_s
);
  logic [STAGES-1:0] ch_q;
  logic [STAGES-1:0] ch_d;

  always_comb ch_d = {ch_q[STAGES-2:0], d_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ch_q <= '0;
    else        ch_q <= ch_d;
  end

  assign q_s = ch_q[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_ctl_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2,
  parameter int RECOV_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  output slp_state_t state_q,
  output logic       flush_q
);
  localparam int MAX_A = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int MAX_C = (MAX_A > RECOV_CYC) ? MAX_A : RECOV_CYC;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] ENT_LD = CW'(ENTRY_CYC - 2);
  localparam logic [CW-1:0] EXT_LD = CW'(EXIT_CYC - 2);
  localparam logic [CW-1:0] REC_LD = CW'(RECOV_CYC - 1);

  slp_state_t    state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          flush_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    flush_d = 1'b0;
    unique case (state_q)
      ST_AWAKE: begin
        if (req_s) begin
          state_d = ST_ENTER;
          cnt_d   = ENT_LD;
          cnt_en  = 1'b1;
        end
      end
      ST_ENTER: begin
        if (!req_s) begin
          state_d = ST_AWAKE;
        end else if (cnt_zero) begin
          state_d = ST_SLEEP;
          flush_d = 1'b1;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (!req_s) begin
          state_d = ST_EXIT;
          cnt_d   = EXT_LD;
          cnt_en  = 1'b1;
        end
      end
      ST_EXIT: begin
        if (req_s) begin
          state_d = ST_SLEEP;
        end else if (cnt_zero) begin
          state_d = ST_RECOV;
          cnt_d   = REC_LD;
          cnt_en  = 1'b1;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt_zero) begin
          state_d = ST_AWAKE;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      flush_q <= 1'b0;
    end else begin
      state_q <= state_d;
      flush_q <= flush_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sleep_err.sv
module sleep_err
  import sleep_ctl_pkg::*;
#(
  parameter int N_SEL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slp_state_t       state_q,
  input  logic             req_s,
  input  logic             busy_i,
  input  logic [N_SEL-1:0] sel_i,
  output logic             err_q
);
  logic viol;
  logic err_en;

  always_comb begin
    viol   = ((state_q == ST_RECOV) && (|sel_i)) ||
             ((state_q == ST_AWAKE) && req_s && busy_i);
    err_en = viol && !err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= 1'b1;
  end
endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl
  import sleep_ctl_pkg::*;
#(
  parameter int N_SEL       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2,
  parameter int RECOV_CYC   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req_a,
  input  logic [N_SEL-1:0] sel_i,
  input  logic             busy_i,
  output logic             sleep_o,
  output logic             flush_o,
  output logic             recov_o,
  output logic             err_o
);
  logic       rst_ns;
  logic       req_s;
  slp_state_t state_q;

  sleep_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ns), .d_a(sleep_req_a), .q_s(req_s)
  );

  sleep_fsm #(
    .ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_ns), .req_s(req_s),
    .state_q(state_q), .flush_q(flush_o)
  );

  sleep_err #(.N_SEL(N_SEL)) u_err (
    .clk(clk), .rst_n(rst_ns), .state_q(state_q), .req_s(req_s),
    .busy_i(busy_i), .sel_i(sel_i), .err_q(err_o)
  );

  assign sleep_o = (state_q == ST_SLEEP) || (state_q == ST_EXIT);
  assign recov_o = (state_q == ST_RECOV);
endmodule

// File: rtl/sleep_ctl_chk.sv
module sleep_ctl_chk #(
  parameter int N_SEL = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_s,
  input logic [N_SEL-1:0] sel_i,
  input logic             sleep_o,
  input logic             flush_o,
  input logic             recov_o,
  input logic             err_o
);
  p_entry_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_o) |-> $past(req_s));
  p_flush_on_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_o) |-> flush_o);
  p_flush_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);
  p_wake_into_recov_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_o) |-> recov_o);
  p_recov_after_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recov_o) |-> !$past(req_s));
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_o && recov_o));
  p_sel_in_recov_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (recov_o && (|sel_i)) |=> err_o);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

bind sleep_ctl sleep_ctl_chk #(.N_SEL(N_SEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_s(req_s), .sel_i(sel_i),
  .sleep_o(sleep_o), .flush_o(flush_o), .recov_o(recov_o), .err_o(err_o)
);

// File: tb/sim_sleep_ctl.sv
`timescale 1ns/1ps
module sim_sleep_ctl;
  localparam int NSEL = 3;
  localparam int RWIN = 2;
  localparam int TENT = 4;

  logic clk;
  logic rst_n;
  logic req;
  logic [NSEL-1:0] sel;
  logic busy;
  logic sleep_w, flush_w, recov_w, err_w;
  int n_vec;
  int n_bad;

  sleep_ctl u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req_a(req), .sel_i(sel), .busy_i(busy),
    .sleep_o(sleep_w), .flush_o(flush_w), .recov_o(recov_w), .err_o(err_w)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    req   = 1'b0;
    sel   = '0;
    busy  = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0;
    n_bad = 0;
    rst_n = 1'b0;
    req   = 1'b0;
    sel   = '0;
    busy  = 1'b0;
    apply_reset();
    chk("R1 sleep", sleep_w, 1'b0);
    chk("R1 flush", flush_w, 1'b0);
    chk("R1 recov", recov_w, 1'b0);
    chk("R1 err", err_w, 1'b0);

    // R2 R3 R4 R5 R7: request pulse width sweep
    for (int L = 1; L <= 6; L++) begin
      apply_reset();
      req = 1'b1;
      for (int n = 1; n <= L + 8; n++) begin
        logic es, er, ef;
        string tg;
        tick();
        if (n == L) req = 1'b0;
        es = (L >= 2) && (n >= TENT) && (n < L + 4);
        er = (L >= 2) && (n >= L + 4) && (n < L + 4 + RWIN);
        ef = (L >= 2) && (n == TENT);
        tg = (L < 2) ? "R5" : ((n < L + 4) ? "R2" : "R3");
        chk($sformatf("%s sleep L=%0d n=%0d", tg, L, n), sleep_w, es);
        chk($sformatf("R4 flush L=%0d n=%0d", L, n), flush_w, ef);
        chk($sformatf("R7 recov L=%0d n=%0d", L, n), recov_w, er);
        chk($sformatf("R10 err L=%0d n=%0d", L, n), err_w, 1'b0);
      end
    end

    // R6: request reopened during exit
    apply_reset();
    req = 1'b1;
    repeat (8) tick();
    req = 1'b0;
    tick();
    req = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      tick();
      chk($sformatf("R6 sleep n=%0d", n), sleep_w, 1'b1);
      chk($sformatf("R6 recov n=%0d", n), recov_w, 1'b0);
      chk($sformatf("R6 flush n=%0d", n), flush_w, 1'b0);
    end

    // R8 R10: enable pulse at each offset after wake, on each bit
    for (int j = 0; j < 4; j++) begin
      for (int b = 0; b < NSEL; b++) begin
        apply_reset();
        req = 1'b1;
        for (int n = 1; n <= 13; n++) begin
          tick();
          if (n == 3) req = 1'b0;
          sel = (n == 7 + j) ? NSEL'(1 << b) : '0;
        end
        chk($sformatf("%s err j=%0d b=%0d", (j < RWIN) ? "R8" : "R10", j, b),
            err_w, (j < RWIN));
      end
    end

    // R9 R10: busy without request, then request while busy
    apply_reset();
    busy = 1'b1;
    repeat (6) tick();
    chk("R10 busy alone err", err_w, 1'b0);
    req = 1'b1;
    repeat (4) tick();
    chk("R9 busy at request err", err_w, 1'b1);
    chk("R9 entry still proceeds", sleep_w, 1'b1);
    req  = 1'b0;
    busy = 1'b0;
    repeat (10) tick();
    chk("R10 err sticky", err_w, 1'b1);
    apply_reset();
    chk("R1 err cleared by reset", err_w, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule